// File: doc/BRIEF.md
# PHY Management Control and Status Registers

This block holds the two generic management registers of a network PHY: a control word at address 0 and a status word at address 1, both 16 bits wide. A management engine (for example the serial frame decoder, which lives elsewhere) reaches them through a simple synchronous port. The port has a write strobe, a read strobe, an address and write data. Read data is registered and shows up on the clock edge that samples the read strobe.

The control word sets three things: power-down, isolation of the media-independent data path, and a collision test mode. From these bits the block drives the oscillator enable, a datapath run enable and a one-cycle reset pulse for the MAC state machine. It also gates the MII signals. On the transmit side, inputs are blocked from the core while isolated. On the receive side, outputs carry a pad output enable and are forced to zero while isolated. The collision output is switched to follow transmit enable in test mode. The status word carries a live link bit and a sticky jabber flag that clears on read. Every other status bit reads zero.

Top module: `phy_mgmt_regs`

## Requirements
- R1: Reset gives the control word 0x0C00: power-down (bit 11) and isolate (bit 10) are 1, and collision test (bit 7) is 0. So `pwr_down_o`=1, `isolate_o`=1, `osc_en_o`=0 and `path_en_o`=0. `mac_sm_rst_o` is 1 while reset is held.
- R2: While power-down is 0, a write to address 0 loads bits 11, 10 and 7 from the write data. Bits 9, 8 and 6..0 always read 0. A read returns the word held before the clock edge that samples it, and `reg_rdata_o` holds that value until the next read.
- R3: While power-down is 1, a write to address 0 changes only bit 11. Bits 10 and 7 keep their values.
- R4: `osc_en_o` and `path_en_o` are both the inverse of the power-down bit.
- R5: `mac_sm_rst_o` is high for exactly one cycle, the same cycle in which a write moves power-down from 0 to 1.
- R6: While isolate is 1, `mii_out_en_o` is 0, every MII output toward the pads is 0, and `core_tx_en_o`, `core_tx_er_o` and `core_txd_o` are 0. Register reads and writes keep working.
- R7: With collision test 1 and isolate 0, `mii_col_o` equals `mii_tx_en_i`.
- R8: With collision test 0 and isolate 0, `mii_col_o` equals `core_col_i`. The receive signals and clocks pass through from the core. With power-down also 0, the transmit inputs pass through to the core.
- R9: A read of address 1 returns `link_ok_i` in bit 2 and the jabber flag in bit 1. All other bits are 0.
- R10: A `jabber_evt_i` pulse sets the jabber flag. A read of address 1 clears it. If an event and a clearing read fall in the same cycle, the flag ends up set, and that read returns the old value.
- R11: A read of any address other than 0 or 1 returns 0. A write to such an address changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| reg_addr_i | input | 5 | Register address |
| reg_wr_en_i | input | 1 | Write strobe |
| reg_wdata_i | input | 16 | Write data |
| reg_rd_en_i | input | 1 | Read strobe |
| reg_rdata_o | output | 16 | Registered read data |
| link_ok_i | input | 1 | Live link indication |
| jabber_evt_i | input | 1 | Jabber detected pulse |
| pwr_down_o | output | 1 | Power-down control bit |
| isolate_o | output | 1 | Isolate control bit |
| osc_en_o | output | 1 | Oscillator enable |
| path_en_o | output | 1 | Transmit/receive datapath run enable |
| mac_sm_rst_o | output | 1 | MAC state machine reset pulse |
| mii_txd_i | input | 4 | MII transmit data |
| mii_tx_en_i | input | 1 | MII transmit enable |
| mii_tx_er_i | input | 1 | MII transmit error |
| core_txd_o | output | 4 | Gated transmit data to core |
| core_tx_en_o | output | 1 | Gated transmit enable to core |
| core_tx_er_o | output | 1 | Gated transmit error to core |
| core_tx_clk_i | input | 1 | Core transmit clock |
| core_rx_clk_i | input | 1 | Core receive clock |
| core_rx_dv_i | input | 1 | Core receive data valid |
| core_rx_er_i | input | 1 | Core receive error |
| core_rxd_i | input | 4 | Core receive data |
| core_col_i | input | 1 | Core collision sense |
| mii_out_en_o | output | 1 | Pad output enable for MII outputs (0 = high impedance) |
| mii_tx_clk_o | output | 1 | MII transmit clock out |
| mii_rx_clk_o | output | 1 | MII receive clock out |
| mii_rx_dv_o | output | 1 | MII receive data valid |
| mii_rx_er_o | output | 1 | MII receive error |
| mii_rxd_o | output | 4 | MII receive data |
| mii_col_o | output | 1 | MII collision |

## Verification
The assertions assume three things about the inputs: the two strobes only matter when sampled, `jabber_evt_i` is a synchronous pulse, and the core's clocks and sense signals are plain levels. The stimulus changes every input on the falling clock edge and holds it across the rising edge that consumes it. Register-port strobes are raised for exactly one cycle per access, so no access is half-sampled. The gating outputs are compared only after the control word has settled, at least half a clock after the write that changed it.

// File: rtl/phy_mgmt_pkg.sv
// Package: shared constants for the PHY management register pair.
// Assumes a 16-bit register word; bit positions are fixed by the
// management register layout that software decodes.
package phy_mgmt_pkg;
    localparam int REG_W      = 16;
    localparam int ADDR_W     = 5;
    localparam int MII_DW     = 4;

    localparam logic [ADDR_W-1:0] ADDR_CTRL = 5'd0;
    localparam logic [ADDR_W-1:0] ADDR_STAT = 5'd1;

    localparam int CB_PDOWN   = 11;
    localparam int CB_ISO     = 10;
    localparam int CB_COLTST  = 7;

    localparam int SB_LINK    = 2;
    localparam int SB_JABBER  = 1;

    localparam logic [REG_W-1:0] CTRL_RST = 16'h0C00;
endpackage

// File: rtl/phy_mgmt_ctrl_reg.sv
// Module: control word storage.
// Holds power-down, isolate and collision-test bits. While power-down is
// set, only the power-down bit accepts a write. Emits a one-cycle MAC
// reset pulse that lines up with power-down turning on.
// Assumes wr_en is already qualified by the control address.
module phy_mgmt_ctrl_reg
    import phy_mgmt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] ctrl_word,
    output logic             pdown,
    output logic             iso,
    output logic             coltest,
    output logic             mac_rst
);
    logic set_pdown_evt;

    // Purpose: flag a write that turns power-down on from off.
    always_comb begin
        set_pdown_evt = wr_en && !pdown && wdata[CB_PDOWN];
    end

    // Purpose: update the control bits, honouring the power-down write lock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pdown   <= CTRL_RST[CB_PDOWN];
            iso     <= CTRL_RST[CB_ISO];
            coltest <= CTRL_RST[CB_COLTST];
        end else if (wr_en) begin
            pdown <= wdata[CB_PDOWN];
            if (!pdown) begin
                iso     <= wdata[CB_ISO];
                coltest <= wdata[CB_COLTST];
            end
        end
    end

    // Purpose: MAC reset output, held in reset and pulsed on power-down entry.
    always_ff @(posedge clk) begin
        if (!rst_n) mac_rst <= 1'b1;
        else        mac_rst <= set_pdown_evt;
    end

    // Purpose: assemble the read-back word, reserved bits as zero.
    always_comb begin
        ctrl_word            = '0;
        ctrl_word[CB_PDOWN]  = pdown;
        ctrl_word[CB_ISO]    = iso;
        ctrl_word[CB_COLTST] = coltest;
    end
endmodule

// File: rtl/phy_mgmt_stat_reg.sv
// Module: status word.
// Carries a live link bit and a sticky jabber flag cleared by a status read.
// A new jabber event in the clearing cycle wins. Assumes rd_clr is the
// read strobe already qualified by the status address.
module phy_mgmt_stat_reg
    import phy_mgmt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             link_ok,
    input  logic             jab_evt,
    input  logic             rd_clr,
    output logic             jabber,
    output logic [REG_W-1:0] stat_word
);
    // Purpose: latch jabber events, clear on status read, set has priority.
    always_ff @(posedge clk) begin
        if (!rst_n)       jabber <= 1'b0;
        else if (jab_evt) jabber <= 1'b1;
        else if (rd_clr)  jabber <= 1'b0;
    end

    // Purpose: assemble status word; capability fields stay zero.
    always_comb begin
        stat_word            = '0;
        stat_word[SB_LINK]   = link_ok;
        stat_word[SB_JABBER] = jabber;
    end
endmodule

// File: rtl/phy_mgmt_mii_gate.sv
// Module: combinational MII gating.
// Blocks transmit inputs from the core when isolated or powered down.
// Zeroes the pad-side outputs and drops their output enable when isolated.
// Selects the collision source for collision test. Assumes the pad ring
// turns mii_out_en low into high impedance.
module phy_mgmt_mii_gate #(
    parameter int DW = 4
) (
    input  logic          iso,
    input  logic          run,
    input  logic          coltest,
    input  logic [DW-1:0] mii_txd,
    input  logic          mii_tx_en,
    input  logic          mii_tx_er,
    output logic [DW-1:0] core_txd,
    output logic          core_tx_en,
    output logic          core_tx_er,
    input  logic          core_tx_clk,
    input  logic          core_rx_clk,
    input  logic          core_rx_dv,
    input  logic          core_rx_er,
    input  logic [DW-1:0] core_rxd,
    input  logic          core_col,
    output logic          mii_out_en,
    output logic          mii_tx_clk,
    output logic          mii_rx_clk,
    output logic          mii_rx_dv,
    output logic          mii_rx_er,
    output logic [DW-1:0] mii_rxd,
    output logic          mii_col
);
    logic tx_pass;
    logic col_src;

    // Purpose: transmit-side gating toward the core.
    always_comb begin
        tx_pass    = !iso && run;
        core_txd   = tx_pass ? mii_txd : '0;
        core_tx_en = tx_pass && mii_tx_en;
        core_tx_er = tx_pass && mii_tx_er;
    end

    // Purpose: pad-side outputs and collision source selection.
    always_comb begin
        col_src    = coltest ? mii_tx_en : core_col;
        mii_out_en = !iso;
        mii_tx_clk = mii_out_en && core_tx_clk;
        mii_rx_clk = mii_out_en && core_rx_clk;
        mii_rx_dv  = mii_out_en && core_rx_dv;
        mii_rx_er  = mii_out_en && core_rx_er;
        mii_rxd    = mii_out_en ? core_rxd : '0;
        mii_col    = mii_out_en && col_src;
    end
endmodule

// File: rtl/phy_mgmt_regs.sv
// Module: top of the PHY management register pair.
// Decodes the register port, holds registered read data, and wires the
// control and status words to the MII gating. Assumes one access strobe
// per cycle from a synchronous management engine.
module phy_mgmt_regs
    import phy_mgmt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic              reg_wr_en_i,
    input  logic [REG_W-1:0]  reg_wdata_i,
    input  logic              reg_rd_en_i,
    output logic [REG_W-1:0]  reg_rdata_o,
    input  logic              link_ok_i,
    input  logic              jabber_evt_i,
    output logic              pwr_down_o,
    output logic              isolate_o,
    output logic              osc_en_o,
    output logic              path_en_o,
    output logic              mac_sm_rst_o,
    input  logic [MII_DW-1:0] mii_txd_i,
    input  logic              mii_tx_en_i,
    input  logic              mii_tx_er_i,
    output logic [MII_DW-1:0] core_txd_o,
    output logic              core_tx_en_o,
    output logic              core_tx_er_o,
    input  logic              core_tx_clk_i,
    input  logic              core_rx_clk_i,
    input  logic              core_rx_dv_i,
    input  logic              core_rx_er_i,
    input  logic [MII_DW-1:0] core_rxd_i,
    input  logic              core_col_i,
    output logic              mii_out_en_o,
    output logic              mii_tx_clk_o,
    output logic              mii_rx_clk_o,
    output logic              mii_rx_dv_o,
    output logic              mii_rx_er_o,
    output logic [MII_DW-1:0] mii_rxd_o,
    output logic              mii_col_o
);
    logic             hit_ctrl, hit_stat;
    logic             ctrl_wr, stat_rd;
    logic [REG_W-1:0] ctrl_word, stat_word, rd_mux;
    logic             pdown_w, iso_w, coltest_w, jabber_w;

    // Purpose: address decode and qualified strobes.
    always_comb begin
        hit_ctrl = (reg_addr_i == ADDR_CTRL);
        hit_stat = (reg_addr_i == ADDR_STAT);
        ctrl_wr  = reg_wr_en_i && hit_ctrl;
        stat_rd  = reg_rd_en_i && hit_stat;
    end

    phy_mgmt_ctrl_reg u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (ctrl_wr),
        .wdata    (reg_wdata_i),
        .ctrl_word(ctrl_word),
        .pdown    (pdown_w),
        .iso      (iso_w),
        .coltest  (coltest_w),
        .mac_rst  (mac_sm_rst_o)
    );

    phy_mgmt_stat_reg u_stat (
        .clk      (clk),
        .rst_n    (rst_n),
        .link_ok  (link_ok_i),
        .jab_evt  (jabber_evt_i),
        .rd_clr   (stat_rd),
        .jabber   (jabber_w),
        .stat_word(stat_word)
    );

    // Purpose: select read data; unmapped addresses return zero.
    always_comb begin
        if (hit_ctrl)      rd_mux = ctrl_word;
        else if (hit_stat) rd_mux = stat_word;
        else               rd_mux = '0;
    end

    // Purpose: register read data on each read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)           reg_rdata_o <= '0;
        else if (reg_rd_en_i) reg_rdata_o <= rd_mux;
    end

    // Purpose: drive control outputs from the control word.
    always_comb begin
        pwr_down_o = pdown_w;
        isolate_o  = iso_w;
        osc_en_o   = !pdown_w;
        path_en_o  = !pdown_w;
    end

    phy_mgmt_mii_gate #(.DW(MII_DW)) u_gate (
        .iso        (iso_w),
        .run        (!pdown_w),
        .coltest    (coltest_w),
        .mii_txd    (mii_txd_i),
        .mii_tx_en  (mii_tx_en_i),
        .mii_tx_er  (mii_tx_er_i),
        .core_txd   (core_txd_o),
        .core_tx_en (core_tx_en_o),
        .core_tx_er (core_tx_er_o),
        .core_tx_clk(core_tx_clk_i),
        .core_rx_clk(core_rx_clk_i),
        .core_rx_dv (core_rx_dv_i),
        .core_rx_er (core_rx_er_i),
        .core_rxd   (core_rxd_i),
        .core_col   (core_col_i),
        .mii_out_en (mii_out_en_o),
        .mii_tx_clk (mii_tx_clk_o),
        .mii_rx_clk (mii_rx_clk_o),
        .mii_rx_dv  (mii_rx_dv_o),
        .mii_rx_er  (mii_rx_er_o),
        .mii_rxd    (mii_rxd_o),
        .mii_col    (mii_col_o)
    );
endmodule

// File: rtl/phy_mgmt_regs_chk.sv
// Module: assertion checker for phy_mgmt_regs, attached by bind.
// Assumes strobes are sampled only on rising edges and reset is synchronous.
module phy_mgmt_regs_chk
    import phy_mgmt_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] reg_addr_i,
    input logic              reg_wr_en_i,
    input logic              reg_rd_en_i,
    input logic [REG_W-1:0]  reg_rdata_o,
    input logic              pwr_down_o,
    input logic              isolate_o,
    input logic              osc_en_o,
    input logic              path_en_o,
    input logic              mac_sm_rst_o,
    input logic              mii_out_en_o,
    input logic              core_tx_en_o,
    input logic              mii_tx_en_i,
    input logic              mii_col_o,
    input logic              jabber_evt_i,
    input logic              coltest_w,
    input logic              jabber_w
);
    p_lock_iso_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_down_o && reg_wr_en_i && reg_addr_i == ADDR_CTRL) |=> $stable(isolate_o));

    p_lock_col_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_down_o && reg_wr_en_i && reg_addr_i == ADDR_CTRL) |=> $stable(coltest_w));

    p_osc_follow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (osc_en_o != pwr_down_o) && (path_en_o == osc_en_o));

    p_mac_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pwr_down_o) |-> mac_sm_rst_o);

    p_mac_only_pd_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mac_sm_rst_o |-> pwr_down_o);

    p_iso_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        isolate_o |-> (!mii_out_en_o && !core_tx_en_o && !mii_col_o));

    p_col_test_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (coltest_w && !isolate_o) |-> (mii_col_o == mii_tx_en_i));

    p_jab_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
        jabber_evt_i |=> jabber_w);

    p_unmapped_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd_en_i && reg_addr_i != ADDR_CTRL && reg_addr_i != ADDR_STAT)
        |=> (reg_rdata_o == '0));
endmodule

bind phy_mgmt_regs phy_mgmt_regs_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_addr_i  (reg_addr_i),
    .reg_wr_en_i (reg_wr_en_i),
    .reg_rd_en_i (reg_rd_en_i),
    .reg_rdata_o (reg_rdata_o),
    .pwr_down_o  (pwr_down_o),
    .isolate_o   (isolate_o),
    .osc_en_o    (osc_en_o),
    .path_en_o   (path_en_o),
    .mac_sm_rst_o(mac_sm_rst_o),
    .mii_out_en_o(mii_out_en_o),
    .core_tx_en_o(core_tx_en_o),
    .mii_tx_en_i (mii_tx_en_i),
    .mii_col_o   (mii_col_o),
    .jabber_evt_i(jabber_evt_i),
    .coltest_w   (coltest_w),
    .jabber_w    (jabber_w)
);

// File: tb/phy_mgmt_regs_tb_top.sv
// Testbench for phy_mgmt_regs: a vector table walk, then directed tests.
module phy_mgmt_regs_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  reg_addr_i = '0;
    logic        reg_wr_en_i = 1'b0;
    logic [15:0] reg_wdata_i = '0;
    logic        reg_rd_en_i = 1'b0;
    logic [15:0] reg_rdata_o;
    logic        link_ok_i = 1'b0;
    logic        jabber_evt_i = 1'b0;
    logic        pwr_down_o, isolate_o, osc_en_o, path_en_o, mac_sm_rst_o;
    logic [3:0]  mii_txd_i = '0;
    logic        mii_tx_en_i = 1'b0;
    logic        mii_tx_er_i = 1'b0;
    logic [3:0]  core_txd_o;
    logic        core_tx_en_o, core_tx_er_o;
    logic        core_tx_clk_i = 1'b0, core_rx_clk_i = 1'b0;
    logic        core_rx_dv_i = 1'b0, core_rx_er_i = 1'b0;
    logic [3:0]  core_rxd_i = '0;
    logic        core_col_i = 1'b0;
    logic        mii_out_en_o, mii_tx_clk_o, mii_rx_clk_o, mii_rx_dv_o, mii_rx_er_o;
    logic [3:0]  mii_rxd_o;
    logic        mii_col_o;

    int n_chk = 0;
    int n_bad = 0;
    logic [15:0] rd_val;

    always #10 clk = ~clk;

    phy_mgmt_regs dut_i (.*);

    // Vector: {write, addr, wdata, expected read}
    localparam int NV = 14;
    localparam logic [37:0] VEC [0:NV-1] = '{
        {1'b0, 5'd0, 16'h0000, 16'h0C00},  // R1 reset word
        {1'b1, 5'd0, 16'hFFFF, 16'h0000},  // R3 locked write
        {1'b0, 5'd0, 16'h0000, 16'h0C00},  // R3 only bit 11 taken
        {1'b1, 5'd0, 16'h0480, 16'h0000},  // R3 clears pdown only
        {1'b0, 5'd0, 16'h0000, 16'h0400},  // R3
        {1'b1, 5'd0, 16'hFFFF, 16'h0000},  // R2 unlocked write
        {1'b0, 5'd0, 16'h0000, 16'h0C80},  // R2 reserved bits zero
        {1'b1, 5'd0, 16'h0000, 16'h0000},  // R3 locked again
        {1'b0, 5'd0, 16'h0000, 16'h0480},  // R3
        {1'b1, 5'd0, 16'h0080, 16'h0000},  // R2
        {1'b0, 5'd0, 16'h0000, 16'h0080},  // R2
        {1'b1, 5'd5, 16'hFFFF, 16'h0000},  // R11 unmapped write
        {1'b0, 5'd5, 16'h0000, 16'h0000},  // R11 unmapped read
        {1'b0, 5'd0, 16'h0000, 16'h0080}   // R11 control untouched
    };

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [4:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_addr_i = a; reg_wdata_i = d; reg_wr_en_i = 1'b1;
        @(negedge clk);
        reg_wr_en_i = 1'b0;
    endtask

    task automatic do_read(input logic [4:0] a, output logic [15:0] d);
        @(negedge clk);
        reg_addr_i = a; reg_rd_en_i = 1'b1;
        @(negedge clk);
        reg_rd_en_i = 1'b0;
        d = reg_rdata_o;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        // R1: reset state while held
        repeat (3) @(negedge clk);
        check("R1 pdown", {15'd0, pwr_down_o}, 16'd1);
        check("R1 iso", {15'd0, isolate_o}, 16'd1);
        check("R1 osc", {15'd0, osc_en_o}, 16'd0);
        check("R1 path", {15'd0, path_en_o}, 16'd0);
        check("R1 macrst", {15'd0, mac_sm_rst_o}, 16'd1);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            if (VEC[i][37]) do_write(VEC[i][36:32], VEC[i][31:16]);
            else begin
                do_read(VEC[i][36:32], rd_val);
                check($sformatf("R2/R3/R11 vec%0d", i), rd_val, VEC[i][15:0]);
            end
        end

        // Now: pdown=0 iso=0 coltest=1
        check("R4 osc on", {15'd0, osc_en_o}, 16'd1);
        check("R4 path on", {15'd0, path_en_o}, 16'd1);
        @(negedge clk);
        mii_tx_en_i = 1'b1; core_col_i = 1'b0;
        #1 check("R7 col follows txen", {15'd0, mii_col_o}, 16'd1);
        @(negedge clk);
        mii_tx_en_i = 1'b0; core_col_i = 1'b1;
        #1 check("R7 col ignores core", {15'd0, mii_col_o}, 16'd0);

        // R8 pass-through with coltest off
        do_write(5'd0, 16'h0000);
        core_col_i = 1'b1; core_rxd_i = 4'hA; core_rx_dv_i = 1'b1;
        mii_tx_en_i = 1'b1; mii_txd_i = 4'h5;
        #1;
        check("R8 col", {15'd0, mii_col_o}, 16'd1);
        check("R8 rxd", {12'd0, mii_rxd_o}, 16'h000A);
        check("R8 rxdv", {15'd0, mii_rx_dv_o}, 16'd1);
        check("R8 txen", {15'd0, core_tx_en_o}, 16'd1);
        check("R8 txd", {12'd0, core_txd_o}, 16'h0005);
        check("R8 oe", {15'd0, mii_out_en_o}, 16'd1);

        // R5 power-down entry pulse
        do_write(5'd0, 16'h0800);
        check("R5 pulse", {15'd0, mac_sm_rst_o}, 16'd1);
        check("R4 osc off", {15'd0, osc_en_o}, 16'd0);
        check("R4 path off", {15'd0, path_en_o}, 16'd0);
        @(negedge clk);
        check("R5 pulse ends", {15'd0, mac_sm_rst_o}, 16'd0);

        // R6 isolate
        do_write(5'd0, 16'h0000);
        check("R5 no pulse on exit", {15'd0, mac_sm_rst_o}, 16'd0);
        do_write(5'd0, 16'h0400);
        check("R6 oe", {15'd0, mii_out_en_o}, 16'd0);
        check("R6 rxd", {12'd0, mii_rxd_o}, 16'd0);
        check("R6 col", {15'd0, mii_col_o}, 16'd0);
        check("R6 txen", {15'd0, core_tx_en_o}, 16'd0);
        check("R6 txd", {12'd0, core_txd_o}, 16'd0);
        do_read(5'd0, rd_val);
        check("R6 mgmt read", rd_val, 16'h0400);

        // R9 status
        link_ok_i = 1'b1;
        do_read(5'd1, rd_val);
        check("R9 link", rd_val, 16'h0004);

        // R10 jabber
        @(negedge clk);
        jabber_evt_i = 1'b1;
        @(negedge clk);
        jabber_evt_i = 1'b0;
        do_read(5'd1, rd_val);
        check("R10 set", rd_val, 16'h0006);
        do_read(5'd1, rd_val);
        check("R10 cleared", rd_val, 16'h0004);
        @(negedge clk);
        reg_addr_i = 5'd1; reg_rd_en_i = 1'b1; jabber_evt_i = 1'b1;
        @(negedge clk);
        reg_rd_en_i = 1'b0; jabber_evt_i = 1'b0;
        check("R10 same-cycle old", reg_rdata_o, 16'h0004);
        do_read(5'd1, rd_val);
        check("R10 set wins", rd_val, 16'h0006);

        // R1 reset again mid-run
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 macrst again", {15'd0, mac_sm_rst_o}, 16'd1);
        rst_n = 1'b1;
        do_read(5'd0, rd_val);
        check("R1 word after reset", rd_val, 16'h0C00);
        do_read(5'd1, rd_val);
        check("R10 reset clears", rd_val, 16'h0004);

        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule